// File: doc/BRIEF.md
# Dual-Core Balanced Dispatcher with Shared Frequency Scaling

This block places each arriving task on one of two cores and keeps one operating level for both cores together. Every cycle it takes at most one arrival (a strobe with a task ID) and one completion strobe per core. From these it keeps a running-task count for each core. It reports each placement as a one-cycle launch command that gives the core and the ID. It drives a power enable per core and a two-bit shared level.

Placement follows a balance rule. An empty core is filled first, core A before core B. If neither core is empty, the task goes to the core that holds fewer tasks. If the two counts are equal, the shared level steps up one notch and the task goes to core A. After completions, the level steps down one notch when the two counts end up equal. The block also meters how long it runs at each level. A fixed-point energy total grows by the per-cycle cost of the present level on every cycle in which a core is powered.

Top module: `dvfs_dispatch`

## Requirements
- R1: After reset both power enables are 0, the level is 0, no launch or busy is shown, and the energy total and all cycle counters are 0.
- R2: An arrival goes to core A when A holds no task, and otherwise to core B when B holds no task. This choice uses the counts after any completion in the same cycle.
- R3: When both cores hold tasks and their counts differ, the arrival goes to the core with the lower count. The level does not change.
- R4: When both cores hold the same non-zero count, an accepted arrival raises the level by one and goes to core A. The level saturates at 2.
- R5: When at least one completion lowers a count and the two counts are then equal, the level drops by one. It saturates at 0, and the level is 0 whenever both counts are 0. A completion strobe for a core that holds no task has no effect.
- R6: When an arrival and completions come in the same cycle, the completions are applied first and the arrival is placed on the counts that result.
- R7: The level encoding is 0 = 100 MHz, 1 = 200 MHz, 2 = 400 MHz, and the value 3 never appears. Power enable bit 0 (core A) and bit 1 (core B) are each 1 exactly while that core's count is non-zero.
- R8: Counts saturate at 15. An arrival whose chosen core already holds 15 tasks is refused: busy is 1 for one cycle, no launch is issued, and the counts and level stay unchanged.
- R9: On each cycle in which a core is powered, the energy total grows by 1238, 1863 or 3492 (units of 0.1 pJ) for level 0, 1 or 2. The total wraps modulo 2^48.
- R10: Three cycle counters count the powered cycles spent at level 0, level 1 and level 2.
- R11: An accepted arrival gives launch_valid for exactly one cycle on the next cycle. On that cycle launch_core (0 = A, 1 = B) and launch_id carry the placement and the arriving ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arr_valid | input | 1 | Task arrival strobe |
| arr_id | input | ID_W | ID of the arriving task |
| done_a | input | 1 | Completion strobe from core A |
| done_b | input | 1 | Completion strobe from core B |
| launch_valid | output | 1 | Launch command valid |
| launch_core | output | 1 | Target core, 0 = A, 1 = B |
| launch_id | output | ID_W | ID of the launched task |
| busy | output | 1 | Arrival refused because the chosen core is full |
| pwr_en | output | 2 | Per-core power enable, bit 0 = A |
| freq_lvl | output | 2 | Shared level, 0/1/2 = 100/200/400 MHz |
| cyc_lo | output | CYC_W | Powered cycles at level 0 |
| cyc_mid | output | CYC_W | Powered cycles at level 1 |
| cyc_hi | output | CYC_W | Powered cycles at level 2 |
| energy | output | EN_W | Energy total, 0.1 pJ per LSB |

## Verification
The embedded properties check several rules on every cycle:
- the level is always legal;
- the level is 0 when both cores are idle;
- the counts and level stay fixed on quiet cycles;
- a tie raises the level and picks core A;
- an arrival at two full cores is refused;
- each energy increment matches the level.

Other behaviour needs the bench scenarios. These are the ordering of completions ahead of an arrival, the step down on a completion that leaves the counts equal, completions ignored on empty cores, and the cycle totals per level over long random runs.

// File: rtl/dd_pkg.sv
package dd_pkg;

    typedef enum logic [1:0] {
        LVL_LO  = 2'd0,
        LVL_MID = 2'd1,
        LVL_HI  = 2'd2
    } lvl_e;

    localparam int NUM_LVL = 3;
    localparam int COST_W  = 12;

    function automatic lvl_e lvl_up(lvl_e l);
        case (l)
            LVL_LO:  return LVL_MID;
            default: return LVL_HI;
        endcase
    endfunction

    function automatic lvl_e lvl_dn(lvl_e l);
        case (l)
            LVL_HI:  return LVL_MID;
            default: return LVL_LO;
        endcase
    endfunction

    // per-cycle cost in 0.1 pJ units
    function automatic logic [COST_W-1:0] lvl_cost(lvl_e l);
        case (l)
            LVL_LO:  return 12'd1238;
            LVL_MID: return 12'd1863;
            default: return 12'd3492;
        endcase
    endfunction

endpackage

// File: rtl/dd_place.sv
module dd_place
    import dd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] cnt_a_i,
    input  logic [CNT_W-1:0] cnt_b_i,
    input  lvl_e             lvl_i,
    input  logic             arr_i,
    input  logic             done_a_i,
    input  logic             done_b_i,
    output logic [CNT_W-1:0] cnt_a_o,
    output logic [CNT_W-1:0] cnt_b_o,
    output lvl_e             lvl_o,
    output logic             take_o,
    output logic             core_o,
    output logic             busy_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam logic [CNT_W-1:0] ONE  = 1;

    logic             ret_a, ret_b, tie;
    logic [CNT_W-1:0] ra, rb;
    lvl_e             rl;

    always_comb begin
        // completions first
        ret_a = done_a_i && (cnt_a_i != '0);
        ret_b = done_b_i && (cnt_b_i != '0);
        ra    = ret_a ? cnt_a_i - ONE : cnt_a_i;
        rb    = ret_b ? cnt_b_i - ONE : cnt_b_i;
        rl    = lvl_i;
        if ((ret_a || ret_b) && (ra == rb)) rl = lvl_dn(lvl_i);
        if ((ra == '0) && (rb == '0))       rl = LVL_LO;

        // then placement on the post-completion counts
        tie    = 1'b0;
        core_o = 1'b0;
        if (ra == '0)      core_o = 1'b0;
        else if (rb == '0) core_o = 1'b1;
        else if (ra < rb)  core_o = 1'b0;
        else if (rb < ra)  core_o = 1'b1;
        else               tie    = 1'b1;

        cnt_a_o = ra;
        cnt_b_o = rb;
        lvl_o   = rl;
        take_o  = 1'b0;
        busy_o  = 1'b0;
        if (arr_i) begin
            if ((core_o ? rb : ra) == CMAX) begin
                busy_o = 1'b1;
            end else begin
                take_o = 1'b1;
                if (core_o) cnt_b_o = rb + ONE;
                else        cnt_a_o = ra + ONE;
                if (tie) lvl_o = lvl_up(rl);
            end
        end
    end

endmodule

// File: rtl/dd_meter.sv
module dd_meter
    import dd_pkg::*;
#(
    parameter int CYC_W = 32,
    parameter int EN_W  = 48
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            active_i,
    input  lvl_e                            lvl_i,
    output logic [NUM_LVL-1:0][CYC_W-1:0]   cyc_o,
    output logic [EN_W-1:0]                 energy_o
);
    localparam logic [CYC_W-1:0] CYC_ONE = 1;

    typedef struct packed {
        logic [NUM_LVL-1:0][CYC_W-1:0] cyc;
        logic [EN_W-1:0]               en;
    } mtr_t;

    mtr_t m_d, m_q;
    logic [EN_W-1:0] cost_ext;

    always_comb begin
        cost_ext = {{(EN_W-COST_W){1'b0}}, lvl_cost(lvl_i)};
        m_d      = m_q;
        if (active_i) begin
            m_d.en = m_q.en + cost_ext;
            for (int i = 0; i < NUM_LVL; i++) begin
                if (int'(lvl_i) == i) m_d.cyc[i] = m_q.cyc[i] + CYC_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign cyc_o    = m_q.cyc;
    assign energy_o = m_q.en;

    p_energy_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |=> energy_o == $past(energy_o) + {{(EN_W-COST_W){1'b0}}, lvl_cost($past(lvl_i))});

    p_energy_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> $stable(energy_o) && $stable(cyc_o));

endmodule

// File: rtl/dvfs_dispatch.sv
module dvfs_dispatch
    import dd_pkg::*;
#(
    parameter int ID_W  = 8,
    parameter int CNT_W = 4,
    parameter int CYC_W = 32,
    parameter int EN_W  = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arr_valid,
    input  logic [ID_W-1:0]  arr_id,
    input  logic             done_a,
    input  logic             done_b,
    output logic             launch_valid,
    output logic             launch_core,
    output logic [ID_W-1:0]  launch_id,
    output logic             busy,
    output logic [1:0]       pwr_en,
    output logic [1:0]       freq_lvl,
    output logic [CYC_W-1:0] cyc_lo,
    output logic [CYC_W-1:0] cyc_mid,
    output logic [CYC_W-1:0] cyc_hi,
    output logic [EN_W-1:0]  energy
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] ca;
        logic [CNT_W-1:0] cb;
        lvl_e             lvl;
        logic             lv;
        logic             lc;
        logic [ID_W-1:0]  lid;
        logic             bsy;
    } st_t;

    st_t s_d, s_q;

    logic [CNT_W-1:0] pl_ca, pl_cb;
    lvl_e             pl_lvl;
    logic             pl_take, pl_core, pl_busy;

    dd_place #(.CNT_W(CNT_W)) u_place (
        .cnt_a_i  (s_q.ca),
        .cnt_b_i  (s_q.cb),
        .lvl_i    (s_q.lvl),
        .arr_i    (arr_valid),
        .done_a_i (done_a),
        .done_b_i (done_b),
        .cnt_a_o  (pl_ca),
        .cnt_b_o  (pl_cb),
        .lvl_o    (pl_lvl),
        .take_o   (pl_take),
        .core_o   (pl_core),
        .busy_o   (pl_busy)
    );

    always_comb begin
        s_d     = s_q;
        s_d.ca  = pl_ca;
        s_d.cb  = pl_cb;
        s_d.lvl = pl_lvl;
        s_d.lv  = pl_take;
        s_d.bsy = pl_busy;
        if (pl_take) begin
            s_d.lc  = pl_core;
            s_d.lid = arr_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.lvl <= LVL_LO;
        end else begin
            s_q <= s_d;
        end
    end

    logic                          active;
    logic [NUM_LVL-1:0][CYC_W-1:0] cyc_all;

    assign active = (s_q.ca != '0) || (s_q.cb != '0);

    dd_meter #(.CYC_W(CYC_W), .EN_W(EN_W)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .lvl_i    (s_q.lvl),
        .cyc_o    (cyc_all),
        .energy_o (energy)
    );

    assign launch_valid = s_q.lv;
    assign launch_core  = s_q.lc;
    assign launch_id    = s_q.lid;
    assign busy         = s_q.bsy;
    assign pwr_en       = {s_q.cb != '0, s_q.ca != '0};
    assign freq_lvl     = s_q.lvl;
    assign cyc_lo       = cyc_all[0];
    assign cyc_mid      = cyc_all[1];
    assign cyc_hi       = cyc_all[2];

    p_lvl_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        freq_lvl != 2'd3);

    p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en == 2'b00) |-> (freq_lvl == 2'd0));

    p_quiet_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!arr_valid && !done_a && !done_b) |=> $stable(freq_lvl) && $stable(pwr_en) && !launch_valid);

    p_tie_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && !done_a && !done_b && s_q.ca == s_q.cb && s_q.ca != '0 && s_q.ca != CMAX)
        |=> launch_valid && !launch_core && (s_q.lvl == lvl_up($past(s_q.lvl))));

    p_full_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && !done_a && !done_b && s_q.ca == CMAX && s_q.cb == CMAX)
        |=> busy && !launch_valid && $stable(freq_lvl));

    p_busy_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && launch_valid));

endmodule

// File: tb/dvfs_dispatch_tb.sv
module dvfs_dispatch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ID_W  = 8;
    localparam int CYC_W = 32;
    localparam int EN_W  = 48;
    localparam int CMAX  = 15;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arr_valid = 1'b0;
    logic [ID_W-1:0]  arr_id = '0;
    logic             done_a = 1'b0;
    logic             done_b = 1'b0;
    logic             launch_valid, launch_core, busy;
    logic [ID_W-1:0]  launch_id;
    logic [1:0]       pwr_en, freq_lvl;
    logic [CYC_W-1:0] cyc_lo, cyc_mid, cyc_hi;
    logic [EN_W-1:0]  energy;

    always #(CLK_PERIOD/2) clk = ~clk;

    dvfs_dispatch #(.ID_W(ID_W), .CNT_W(4), .CYC_W(CYC_W), .EN_W(EN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_id(arr_id),
        .done_a(done_a), .done_b(done_b), .launch_valid(launch_valid),
        .launch_core(launch_core), .launch_id(launch_id), .busy(busy),
        .pwr_en(pwr_en), .freq_lvl(freq_lvl), .cyc_lo(cyc_lo), .cyc_mid(cyc_mid),
        .cyc_hi(cyc_hi), .energy(energy)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // reference state
    int ea = 0, eb = 0, el = 0;
    bit ev = 0, ec = 0, ebz = 0;
    int eid = 0;
    longint eng = 0;
    longint ecyc [3] = '{0, 0, 0};
    string ptag = "R2";
    string ltag = "R4";

    function automatic int cost(int l);
        return (l == 0) ? 1238 : (l == 1) ? 1863 : 3492;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model(bit arr, int id, bit da, bit db);
        int ra, rb, rl, tgt;
        bit tie, reta, retb;
        if (ea != 0 || eb != 0) begin
            eng = (eng + cost(el)) & ((64'sd1 <<< 48) - 1);
            ecyc[el]++;
        end
        reta = da && ea != 0;
        retb = db && eb != 0;
        ra = ea - (reta ? 1 : 0);
        rb = eb - (retb ? 1 : 0);
        rl = el;
        ltag = "R4";
        if ((reta || retb) && ra == rb) begin rl = (el > 0) ? el - 1 : 0; ltag = "R5"; end
        if (ra == 0 && rb == 0) rl = 0;
        tie = 0;
        if (ra == 0)       begin tgt = 0; ptag = "R2"; end
        else if (rb == 0)  begin tgt = 1; ptag = "R2"; end
        else if (ra < rb)  begin tgt = 0; ptag = "R3"; end
        else if (rb < ra)  begin tgt = 1; ptag = "R3"; end
        else               begin tgt = 0; tie = 1; ptag = "R4"; end
        if (da || db) ptag = "R6";
        ev = 0; ebz = 0;
        if (arr) begin
            if (((tgt == 1) ? rb : ra) == CMAX) ebz = 1;
            else begin
                ev = 1; ec = tgt[0]; eid = id;
                if (tgt == 1) rb++; else ra++;
                if (tie) rl = (rl < 2) ? rl + 1 : 2;
            end
        end
        ea = ra; eb = rb; el = rl;
    endtask

    task automatic compare();
        chk(launch_valid == ev, "R11", launch_valid, ev);
        if (ev) begin
            chk(launch_core == ec, ptag, launch_core, ec);
            chk(int'(launch_id) == eid, "R11", launch_id, eid);
        end
        chk(busy == ebz, "R8", busy, ebz);
        chk(int'(freq_lvl) == el, ltag, freq_lvl, el);
        chk(pwr_en == {eb != 0, ea != 0}, "R7", pwr_en, {eb != 0, ea != 0});
        chk(longint'(energy) == eng, "R9", energy, eng);
        chk(longint'(cyc_lo) == ecyc[0] && longint'(cyc_mid) == ecyc[1] &&
            longint'(cyc_hi) == ecyc[2], "R10", cyc_hi, ecyc[2]);
    endtask

    task automatic step(bit arr, int id, bit da, bit db);
        arr_valid = arr; arr_id = id[ID_W-1:0]; done_a = da; done_b = db;
        model(arr, id, da, db);
        @(negedge clk);
        compare();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pwr_en == 2'b00 && freq_lvl == 2'd0 && !launch_valid && !busy, "R1", {pwr_en, freq_lvl}, 0);
        chk(energy == '0 && cyc_lo == '0 && cyc_mid == '0 && cyc_hi == '0, "R1", energy, 0);
        rst_n = 1'b1;
        // fill both cores to saturation: R2, R3, R4
        for (int i = 0; i < 30; i++) step(1, i + 1, 0, 0);
        // R8 full refusal
        step(1, 99, 0, 0);
        step(1, 98, 0, 0);
        // R5 completion on one core then the other
        step(0, 0, 1, 0);
        step(0, 0, 0, 1);
        // R6 simultaneous completion and arrival
        step(1, 77, 1, 0);
        // drain, then strobes on empty cores (R5 ignored)
        for (int i = 0; i < 18; i++) step(0, 0, 1, 1);
        step(0, 0, 1, 1);
        // R2: only B loaded, arrival goes to A
        step(1, 5, 0, 0);
        step(1, 6, 0, 0);
        step(0, 0, 1, 0);
        step(1, 7, 0, 0);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit a, x, y;
            a = ($urandom % 2) == 0;
            x = ($urandom % 3) == 0;
            y = ($urandom % 3) == 0;
            step(a, int'($urandom % 256), x, y);
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule